// File: doc/BRIEF.md
# Branch and Loop Condition Evaluator

This block decides whether a conditional control transfer is taken. In compare mode it reads a 4-bit condition selector and the five status flags (carry, zero, sign, overflow, parity) and reports whether the selected condition holds. It covers tests on a single flag, unsigned magnitude tests and signed magnitude tests. The lowest selector bit inverts the sense of any condition.

In loop mode it takes the 16-bit count value and reduces it by one. It reports the new count with a write enable so that the register file can store it. The branch is taken while the new count is nonzero. Two loop kinds also require the zero flag to be set or to be clear. The decrement wraps from 0000h to FFFFh, so a loop entered with a zero count runs 65536 times. The block never produces flags.

A request is presented for one cycle with `req_valid`. The decision, the new count and the write enable are registered and appear on the outputs in the following cycle together with `res_valid`. Target address computation and instruction fetch are handled elsewhere.

Top module: `branch_loop_eval`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `res_valid`, `res_taken`, `count_we` and `count_out` are all 0.
- R2: Results appear exactly one clock after a cycle with `req_valid`=1, with `res_valid`=1. After a cycle with `req_valid`=0, `res_valid`, `res_taken` and `count_we` are 0.
- R3: In compare mode (`req_is_loop`=0), `cond_sel[3:1]` picks the base condition. The single-flag codes are 000 = OF, 001 = CF, 010 = ZF, 100 = SF and 101 = PF, each true when the flag is 1.
- R4: Unsigned codes: `cond_sel`=0110 (below or equal) is taken when CF=1 or ZF=1. 0111 (above) is taken when CF=0 and ZF=0. 0010 (below) is taken when CF=1, and 0011 (above or equal) when CF=0.
- R5: Signed codes: 1100 (less) is taken when SF differs from OF. 1101 (greater or equal) is taken when SF equals OF. 1110 (less or equal) is taken when ZF=1 or SF differs from OF. 1111 (greater) is taken when ZF=0 and SF equals OF.
- R6: `cond_sel[0]`=1 inverts the base condition picked by `cond_sel[3:1]`.
- R7: In compare mode, `count_we` is 0 and `count_out` equals the `count_in` that was presented. `loop_kind` has no effect.
- R8: In loop mode (`req_is_loop`=1), `count_we` is 1 and `count_out` is `count_in` minus 1. For `loop_kind` 00 (plain) and 11 (treated as plain), the branch is taken exactly when that new count is nonzero.
- R9: `loop_kind` 01 is taken only if the new count is nonzero and ZF=1. `loop_kind` 10 is taken only if the new count is nonzero and ZF=0.
- R10: A loop with `count_in`=0000h yields `count_out`=FFFFh and is taken. A loop with `count_in`=0001h yields 0000h and is not taken.
- R11: In loop mode, `cond_sel` has no effect, and CF, SF, OF and PF have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_loop | input | 1 | 1 = loop mode, 0 = compare mode |
| cond_sel | input | 4 | Condition selector; bit 0 inverts |
| loop_kind | input | 2 | 00 plain, 01 while zero set, 10 while zero clear, 11 plain |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_pf | input | 1 | Parity flag |
| count_in | input | 16 | Current count register value |
| res_valid | output | 1 | Result valid |
| res_taken | output | 1 | Branch taken |
| count_out | output | 16 | New count value |
| count_we | output | 1 | Write enable for the count register |

## Verification
All results, including the taken bit, the new count and its write enable, come from one register stage. They are therefore due at the first rising edge after the cycle in which the request is held. The bench drives each request on a falling edge and checks its outputs on the next falling edge, half a period after that rising edge, before the following request can affect them. Idle cycles are checked in the same way, one edge after `req_valid` drops. The reset values are checked while reset is still held.

// File: rtl/bl_pkg.sv
package bl_pkg;

    // Base conditions, selected by cond_sel[3:1]
    typedef enum logic [2:0] {
        BASE_OVF   = 3'd0,
        BASE_CARRY = 3'd1,
        BASE_ZERO  = 3'd2,
        BASE_BE    = 3'd3,
        BASE_SIGN  = 3'd4,
        BASE_PAR   = 3'd5,
        BASE_LT    = 3'd6,
        BASE_LE    = 3'd7
    } base_cond_e;

    typedef enum logic [1:0] {
        LOOP_PLAIN    = 2'd0,
        LOOP_WHILE_EQ = 2'd1,
        LOOP_WHILE_NE = 2'd2,
        LOOP_ALT      = 2'd3
    } loop_kind_e;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
        logic pf;
    } flags_t;

    localparam int SEL_W  = 4;
    localparam int KIND_W = 2;
    localparam int NBASE  = 1 << (SEL_W - 1);

endpackage

// File: rtl/bl_cond_eval.sv
module bl_cond_eval
    import bl_pkg::*;
(
    input  flags_t           flags,
    input  logic [SEL_W-1:0] sel,
    output logic             met
);
    logic [NBASE-1:0] base;
    logic             sign_ne_ovf;

    always_comb begin
        sign_ne_ovf      = flags.sf ^ flags.of;
        base             = '0;
        base[BASE_OVF]   = flags.of;
        base[BASE_CARRY] = flags.cf;
        base[BASE_ZERO]  = flags.zf;
        base[BASE_BE]    = flags.cf | flags.zf;
        base[BASE_SIGN]  = flags.sf;
        base[BASE_PAR]   = flags.pf;
        base[BASE_LT]    = sign_ne_ovf;
        base[BASE_LE]    = flags.zf | sign_ne_ovf;
        met              = base[sel[SEL_W-1:1]] ^ sel[0];
    end
endmodule

// File: rtl/bl_loop_step.sv
module bl_loop_step
    import bl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0]  count_in,
    input  logic [KIND_W-1:0] kind,
    input  logic              zf,
    output logic [CNT_W-1:0]  count_next,
    output logic              taken
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic nonzero;
    logic qual;

    always_comb begin
        count_next = count_in - ONE;
        nonzero    = |count_next;
        unique case (kind)
            LOOP_WHILE_EQ: qual = zf;
            LOOP_WHILE_NE: qual = ~zf;
            default:       qual = 1'b1;
        endcase
        taken = nonzero & qual;
    end
endmodule

// File: rtl/branch_loop_eval.sv
module branch_loop_eval
    import bl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_loop,
    input  logic [SEL_W-1:0]  cond_sel,
    input  logic [KIND_W-1:0] loop_kind,
    input  logic              flag_cf,
    input  logic              flag_zf,
    input  logic              flag_sf,
    input  logic              flag_of,
    input  logic              flag_pf,
    input  logic [CNT_W-1:0]  count_in,
    output logic              res_valid,
    output logic              res_taken,
    output logic [CNT_W-1:0]  count_out,
    output logic              count_we
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             valid;
        logic             taken;
        logic             we;
        logic [CNT_W-1:0] count;
    } state_t;

    state_t           state_d, state_q;
    flags_t           flags;
    logic             cond_met;
    logic             loop_taken;
    logic [CNT_W-1:0] loop_next;

    assign flags = '{cf: flag_cf, zf: flag_zf, sf: flag_sf, of: flag_of, pf: flag_pf};

    bl_cond_eval u_cond (
        .flags (flags),
        .sel   (cond_sel),
        .met   (cond_met)
    );

    bl_loop_step #(.CNT_W(CNT_W)) u_loop (
        .count_in   (count_in),
        .kind       (loop_kind),
        .zf         (flag_zf),
        .count_next (loop_next),
        .taken      (loop_taken)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = req_valid;
        state_d.taken = 1'b0;
        state_d.we    = 1'b0;
        if (req_valid) begin
            if (req_is_loop) begin
                state_d.taken = loop_taken;
                state_d.we    = 1'b1;
                state_d.count = loop_next;
            end else begin
                state_d.taken = cond_met;
                state_d.count = count_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign res_valid = state_q.valid;
    assign res_taken = state_q.taken;
    assign count_we  = state_q.we;
    assign count_out = state_q.count;

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_taken && !count_we));

    // R7
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(req_is_loop)) |-> (!count_we && count_out == $past(count_in)));

    // R8
    dec_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(req_is_loop)) |-> (count_we && count_out == $past(count_in) - ONE));

    // R8
    taken_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_taken && count_we) |-> (count_out != '0));

    // R9
    while_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_taken && count_we && $past(loop_kind) == LOOP_WHILE_EQ) |-> $past(flag_zf));

    // R9
    while_ne_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_taken && count_we && $past(loop_kind) == LOOP_WHILE_NE) |-> !$past(flag_zf));
endmodule

// File: tb/branch_loop_eval_tb.sv
module branch_loop_eval_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_loop = 1'b0;
    logic [3:0]  cond_sel = '0;
    logic [1:0]  loop_kind = '0;
    logic        flag_cf = 1'b0, flag_zf = 1'b0, flag_sf = 1'b0, flag_of = 1'b0, flag_pf = 1'b0;
    logic [15:0] count_in = '0;
    logic        res_valid, res_taken, count_we;
    logic [15:0] count_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    branch_loop_eval u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_loop(req_is_loop),
        .cond_sel(cond_sel), .loop_kind(loop_kind), .flag_cf(flag_cf), .flag_zf(flag_zf),
        .flag_sf(flag_sf), .flag_of(flag_of), .flag_pf(flag_pf), .count_in(count_in),
        .res_valid(res_valid), .res_taken(res_taken), .count_out(count_out), .count_we(count_we)
    );

    // {is_loop, cond[3:0], kind[1:0], flags{cf,zf,sf,of,pf}, count[15:0], exp_taken, exp_we, exp_count[15:0]}
    localparam int NV = 15;
    localparam logic [45:0] VEC [NV] = '{
        {1'b0, 4'b0111, 2'b00, 5'b00000, 16'h1234, 1'b1, 1'b0, 16'h1234}, // R4 above
        {1'b0, 4'b0111, 2'b00, 5'b10000, 16'h1234, 1'b0, 1'b0, 16'h1234}, // R4 above, CF set
        {1'b0, 4'b1111, 2'b00, 5'b00110, 16'h0042, 1'b1, 1'b0, 16'h0042}, // R5 greater
        {1'b0, 4'b1100, 2'b00, 5'b00100, 16'h0042, 1'b1, 1'b0, 16'h0042}, // R5 less
        {1'b0, 4'b1011, 2'b00, 5'b00001, 16'h0042, 1'b0, 1'b0, 16'h0042}, // R6 no parity
        {1'b1, 4'b0000, 2'b00, 5'b00000, 16'h0005, 1'b1, 1'b1, 16'h0004}, // R8 plain
        {1'b1, 4'b0000, 2'b00, 5'b00000, 16'h0001, 1'b0, 1'b1, 16'h0000}, // R10 to zero
        {1'b1, 4'b0000, 2'b00, 5'b00000, 16'h0000, 1'b1, 1'b1, 16'hFFFF}, // R10 wrap
        {1'b1, 4'b0000, 2'b01, 5'b01000, 16'h0003, 1'b1, 1'b1, 16'h0002}, // R9 eq, ZF=1
        {1'b1, 4'b0000, 2'b01, 5'b00000, 16'h0003, 1'b0, 1'b1, 16'h0002}, // R9 eq, ZF=0
        {1'b1, 4'b0000, 2'b10, 5'b00000, 16'h0003, 1'b1, 1'b1, 16'h0002}, // R9 ne, ZF=0
        {1'b1, 4'b0000, 2'b10, 5'b01000, 16'h0003, 1'b0, 1'b1, 16'h0002}, // R9 ne, ZF=1
        {1'b1, 4'b1111, 2'b11, 5'b11111, 16'h0010, 1'b1, 1'b1, 16'h000F}, // R11 kind 11, all flags
        {1'b0, 4'b0100, 2'b10, 5'b01000, 16'hABCD, 1'b1, 1'b0, 16'hABCD}, // R7 zero, kind ignored
        {1'b1, 4'b0000, 2'b01, 5'b01000, 16'h0001, 1'b0, 1'b1, 16'h0000}  // R9 eq, count ends
    };
    localparam int VTAG [NV] = '{4, 4, 5, 5, 6, 8, 10, 10, 9, 9, 9, 9, 11, 7, 9};

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic model_cond(input logic [3:0] s, input logic cf, zf, sf, of, pf);
        logic b;
        case (s[3:1])
            3'd0: b = of;
            3'd1: b = cf;
            3'd2: b = zf;
            3'd3: b = cf || zf;
            3'd4: b = sf;
            3'd5: b = pf;
            3'd6: b = (sf != of);
            default: b = zf || (sf != of);
        endcase
        return s[0] ? !b : b;
    endfunction

    task automatic drive(input logic lp, input logic [3:0] cs, input logic [1:0] k,
                         input logic [4:0] f, input logic [15:0] c);
        req_valid = 1'b1; req_is_loop = lp; cond_sel = cs; loop_kind = k;
        {flag_cf, flag_zf, flag_sf, flag_of, flag_pf} = f; count_in = c;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs at zero even with a request present
        @(negedge clk);
        req_valid = 1'b1; req_is_loop = 1'b1; count_in = 16'h0007;
        repeat (3) @(negedge clk);
        chk("R1 res_valid", {15'd0, res_valid}, 16'd0);
        chk("R1 taken", {15'd0, res_taken}, 16'd0);
        chk("R1 we", {15'd0, count_we}, 16'd0);
        chk("R1 count", count_out, 16'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {13'd0, res_valid, res_taken, count_we}, 16'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][45], VEC[i][44:41], VEC[i][40:39], VEC[i][38:34], VEC[i][33:18]);
            chk($sformatf("R%0d vec%0d taken", VTAG[i], i), {15'd0, res_taken}, {15'd0, VEC[i][17]});
            chk($sformatf("R%0d vec%0d we", VTAG[i], i), {15'd0, count_we}, {15'd0, VEC[i][16]});
            chk($sformatf("R%0d vec%0d count", VTAG[i], i), count_out, VEC[i][15:0]);
            chk($sformatf("R2 vec%0d valid", i), {15'd0, res_valid}, 16'd1);
        end

        // R2: idle cycle
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 idle valid/taken/we", {13'd0, res_valid, res_taken, count_we}, 16'd0);

        // R3 R4 R5 R6: every selector against every flag pattern
        for (int s = 0; s < 16; s++) begin
            for (int f = 0; f < 32; f++) begin
                logic [4:0] fv;
                logic       e;
                string      tg;
                fv = 5'(f);
                e  = model_cond(4'(s), fv[4], fv[3], fv[2], fv[1], fv[0]);
                if (s[0])                         tg = "R6";
                else if (s[3:1] == 3'd3)          tg = "R4";
                else if (s[3:1] >= 3'd6)          tg = "R5";
                else                              tg = "R3";
                drive(1'b0, 4'(s), 2'(f), fv, 16'(f * 977));
                chk($sformatf("%s sel=%0d flags=%b", tg, s, fv), {15'd0, res_taken}, {15'd0, e});
                chk($sformatf("R7 sel=%0d flags=%b", s, fv), {15'd0, count_we}, 16'd0);
            end
        end

        // R8 R9 R10 R11: loop kinds, zero flag, boundary counts, other flags and selectors
        for (int k = 0; k < 4; k++) begin
            for (int z = 0; z < 2; z++) begin
                for (int ci = 0; ci < 5; ci++) begin
                    logic [15:0] c;
                    logic [15:0] n;
                    logic        q;
                    logic [4:0]  fv;
                    case (ci)
                        0: c = 16'h0000;
                        1: c = 16'h0001;
                        2: c = 16'h0002;
                        3: c = 16'h8000;
                        default: c = 16'hFFFF;
                    endcase
                    n  = c - 16'd1;
                    q  = (k == 1) ? (z == 1) : (k == 2) ? (z == 0) : 1'b1;
                    fv = {ci[0], 1'(z), ci[1], k[0], ci[2]};
                    drive(1'b1, 4'(ci * 3 + k), 2'(k), fv, c);
                    chk($sformatf("R9 kind=%0d zf=%0d cnt=%h taken", k, z, c),
                        {15'd0, res_taken}, {15'd0, (n != 16'd0) && q});
                    chk($sformatf("R10 kind=%0d cnt=%h count", k, c), count_out, n);
                    chk($sformatf("R8 kind=%0d we", k), {15'd0, count_we}, 16'd1);
                end
            end
        end

        // R11: same loop request with every other flag flipped gives same result
        drive(1'b1, 4'b0101, 2'b00, 5'b00000, 16'h0009);
        chk("R11 base taken", {15'd0, res_taken}, 16'd1);
        drive(1'b1, 4'b1010, 2'b00, 5'b10111, 16'h0009);
        chk("R11 flipped taken", {15'd0, res_taken}, 16'd1);
        chk("R11 flipped count", count_out, 16'h0008);

        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 final idle", {13'd0, res_valid, res_taken, count_we}, 16'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule